// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a simple memory read port and an instruction consumer. It keeps up to six upcoming instruction bytes in a strict first-in, first-out byte queue. Whenever the queue has enough free room it issues a read for the next chunk of code. The consumer drains the queue one byte at a time, and it can do so in the same cycle that a fetched chunk lands. The read address is a 20-bit physical address. It is the 16-bit code segment value multiplied by 16 plus a 16-bit fetch pointer. The pointer wraps inside its 64 KB window and never carries into the segment.

A redirect input (a taken branch) empties the queue and reloads the fetch pointer. Any read already accepted by memory is still answered, but its data is dropped. The parameter `BUS_W` selects a 16-bit bus, which fetches little-endian words, or an 8-bit bus, which fetches single bytes. On the 16-bit bus an odd fetch pointer first triggers a one-byte read to realign, and word reads follow from there. Only one read is in flight at a time.

The fetch controller is a four-state machine:
- FS_IDLE waits for room. It moves to FS_ISSUE when the free space is at least one bus width, and it stays in FS_IDLE on a redirect.
- FS_ISSUE presents the request. It moves to FS_WAIT when the request is accepted. On a redirect it moves to FS_IDLE if the request was not accepted that cycle, or to FS_DRAIN if it was.
- FS_WAIT waits for the data. On a response it pushes the bytes and returns to FS_IDLE. On a redirect without a response it moves to FS_DRAIN. On a redirect together with a response it discards the data and returns to FS_IDLE.
- FS_DRAIN swallows the stale response and then returns to FS_IDLE.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most 6 bytes (`count` never exceeds 6). Bytes leave in exactly the order they arrived.
- R2: With `BUS_W`=16 a read is requested only while `count` is 4 or less, that is, while at least 2 bytes are free.
- R3: With `BUS_W`=8 a read is requested while `count` is 5 or less. Every read is a byte read (`mem_req_word`=0), and its byte is taken from `mem_rsp_data[7:0]`. With no consumption the queue fills to 6.
- R4: `mem_req_addr` equals (`cs_seg` × 16 + fetch pointer) modulo 2^20.
- R5: A redirect clears the queue: `count`=0 and `empty`=1 in the following cycle. A pop or a response in the same cycle as the redirect has no effect. The next byte delivered comes from the new address.
- R6: A word read (`mem_req_word`=1) always has an even address. `mem_rsp_data[7:0]` (the lower address) enters the queue before `mem_rsp_data[15:8]`.
- R7: With `BUS_W`=16 and an odd fetch pointer, one byte read is issued at the odd address and its byte is taken from `mem_rsp_data[15:8]`. The pointer then becomes even and word reads follow. From an odd start with no consumption the queue settles at 5 bytes.
- R8: A response to a read accepted before, or in the same cycle as, a redirect is discarded.
- R9: The fetch pointer advances modulo 65536. Passing 0xFFFF does not change the segment value used in the address.
- R10: Once raised, `mem_req_valid` stays high with a stable address until `mem_req_ready`, unless a redirect occurs.
- R11: A response and a pop in the same cycle are both honoured: `count` becomes the old count plus the bytes pushed minus one.
- R12: `pop_valid` is high exactly when `count` > 0. `empty` is high exactly when `count` = 0. `head_byte` is the oldest queued byte.
- R13: During reset the queue is empty (`count`=0, `empty`=1) and no read is requested. After reset, fetching starts at pointer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_seg | input | 16 | Code segment value used for address formation |
| redirect | input | 1 | Branch: flush queue and reload fetch pointer |
| redirect_ptr | input | 16 | New fetch pointer loaded on redirect |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 20 | Physical read address |
| mem_req_word | output | 1 | 1 = two-byte read, 0 = one-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | BUS_W | Read data, lower address in the low byte |
| pop_valid | output | 1 | A byte is available to the consumer |
| pop_ready | input | 1 | Consumer takes the head byte this cycle |
| head_byte | output | 8 | Oldest queued byte |
| count | output | 3 | Number of queued bytes |
| empty | output | 1 | Queue holds no bytes |

## Verification
The assertions assume three things about the inputs. Memory returns exactly one response per accepted read, no earlier than the cycle after acceptance, and never returns data unasked. `cs_seg` changes only in a cycle where `redirect` is high. The bench memory model enforces the first: it holds a single outstanding read with a random latency of one to three cycles and answers every accepted read, stale ones included. The stimulus enforces the second by changing the segment only together with a redirect pulse. Ready, pop and redirect patterns are otherwise random, so requests, responses, pops and flushes collide in every combination.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ISSUE,
        FS_WAIT,
        FS_DRAIN
    } fetch_state_t;

endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 20,
    parameter int SHIFT  = 4
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] phys
);

    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] offs_w;

    always_comb begin
        base_w = ADDR_W'(seg) << SHIFT;
        offs_w = ADDR_W'(ptr);
        phys   = base_w + offs_w;
    end

endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_b0,
    input  logic [7:0]       push_b1,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count,
    output logic             empty
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
        if (int'(i) == DEPTH - 1) return '0;
        return i + 1'b1;
    endfunction

    logic [7:0]       store [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] wr_idx1;
    logic [IDX_W-1:0] wr_idx2;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        wr_idx1 = wrap_inc(wr_idx);
        wr_idx2 = wrap_inc(wr_idx1);
    end

    always_ff @(posedge clk) begin
        if (!flush) begin
            if (push_n != 2'd0) store[wr_idx] <= push_b0;
            if (push_n == 2'd2) store[wr_idx1] <= push_b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_idx <= '0;
            wr_idx <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_n == 2'd2)      wr_idx <= wr_idx2;
            else if (push_n == 2'd1) wr_idx <= wr_idx1;
            if (pop) rd_idx <= wrap_inc(rd_idx);
            cnt_q <= cnt_q + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    always_comb begin
        head  = store[rd_idx];
        count = cnt_q;
        empty = (cnt_q == '0);
    end

    // R1: occupancy bound
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= DEPTH);

    // R5: flush empties the queue on the next cycle
    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));

endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int BUS_BYTES = 2,
    parameter int DEPTH     = 6,
    parameter int CNT_W     = 3,
    parameter int PTR_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect,
    input  logic [PTR_W-1:0] redirect_ptr,
    input  logic [CNT_W-1:0] count,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [BUS_W-1:0] rsp_data,
    output logic             req_valid,
    output logic             req_word,
    output logic [PTR_W-1:0] fetch_ptr,
    output logic [1:0]       push_n,
    output logic [7:0]       push_b0,
    output logic [7:0]       push_b1
);

    localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - BUS_BYTES);

    fetch_state_t     state_q;
    fetch_state_t     state_d;
    logic [PTR_W-1:0] ptr_q;
    logic             room;
    logic             take_rsp;
    logic             word_fetch;
    logic [1:0]       fetch_size;
    logic [7:0]       first_b;
    logic [7:0]       second_b;

    generate
        if (BUS_BYTES == 2) begin : g_wide
            always_comb begin
                word_fetch = !ptr_q[0];
                fetch_size = ptr_q[0] ? 2'd1 : 2'd2;
                first_b    = ptr_q[0] ? rsp_data[15:8] : rsp_data[7:0];
                second_b   = rsp_data[15:8];
            end
        end else begin : g_narrow
            always_comb begin
                word_fetch = 1'b0;
                fetch_size = 2'd1;
                first_b    = rsp_data[7:0];
                second_b   = rsp_data[7:0];
            end
        end
    endgenerate

    always_comb begin
        room     = (count <= ROOM_LIMIT);
        take_rsp = (state_q == FS_WAIT) && rsp_valid && !redirect;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (!redirect && room) state_d = FS_ISSUE;
            end
            FS_ISSUE: begin
                if (redirect)       state_d = req_ready ? FS_DRAIN : FS_IDLE;
                else if (req_ready) state_d = FS_WAIT;
            end
            FS_WAIT: begin
                if (rsp_valid)     state_d = FS_IDLE;
                else if (redirect) state_d = FS_DRAIN;
            end
            FS_DRAIN: begin
                if (rsp_valid) state_d = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // fetch pointer
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (redirect) ptr_q <= redirect_ptr;
        else if (take_rsp) ptr_q <= ptr_q + PTR_W'(fetch_size);
    end

    // outputs
    always_comb begin
        req_valid = (state_q == FS_ISSUE);
        req_word  = word_fetch;
        fetch_ptr = ptr_q;
        push_n    = take_rsp ? fetch_size : 2'd0;
        push_b0   = first_b;
        push_b1   = second_b;
    end

    // R10: an unaccepted request is held with the same pointer
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !redirect) |=> (req_valid && $stable(ptr_q)));

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int DEPTH  = 6,
    parameter int SEG_W  = 16,
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  cs_seg,
    input  logic              redirect,
    input  logic [PTR_W-1:0]  redirect_ptr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_word,
    input  logic              mem_rsp_valid,
    input  logic [BUS_W-1:0]  mem_rsp_data,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [7:0]        head_byte,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              empty
);

    localparam int BUS_BYTES = BUS_W / 8;
    localparam int CNT_W     = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] fetch_ptr;
    logic [1:0]       push_n;
    logic [7:0]       push_b0;
    logic [7:0]       push_b1;
    logic             do_pop;
    logic             q_empty;
    logic [CNT_W-1:0] q_count;

    pfq_addr_gen #(
        .SEG_W (SEG_W),
        .PTR_W (PTR_W),
        .ADDR_W(ADDR_W),
        .SHIFT (4)
    ) u_addr (
        .seg (cs_seg),
        .ptr (fetch_ptr),
        .phys(mem_req_addr)
    );

    pfq_fetch_ctl #(
        .BUS_W    (BUS_W),
        .BUS_BYTES(BUS_BYTES),
        .DEPTH    (DEPTH),
        .CNT_W    (CNT_W),
        .PTR_W    (PTR_W)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .redirect    (redirect),
        .redirect_ptr(redirect_ptr),
        .count       (q_count),
        .req_ready   (mem_req_ready),
        .rsp_valid   (mem_rsp_valid),
        .rsp_data    (mem_rsp_data),
        .req_valid   (mem_req_valid),
        .req_word    (mem_req_word),
        .fetch_ptr   (fetch_ptr),
        .push_n      (push_n),
        .push_b0     (push_b0),
        .push_b1     (push_b1)
    );

    always_comb begin
        do_pop    = !q_empty && pop_ready && !redirect;
        pop_valid = !q_empty;
        empty     = q_empty;
        count     = q_count;
    end

    pfq_byte_fifo #(
        .DEPTH(DEPTH),
        .CNT_W(CNT_W)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (redirect),
        .push_n (push_n),
        .push_b0(push_b0),
        .push_b1(push_b1),
        .pop    (do_pop),
        .head   (head_byte),
        .count  (q_count),
        .empty  (q_empty)
    );

    // R2 (and R3 for the byte bus): requests only with a bus width of free room
    a_r2_room: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (int'(q_count) <= DEPTH - BUS_BYTES));

    // R6: word reads are aligned
    a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_word) |-> !mem_req_addr[0]);

endmodule

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps

module pfq_lane #(
    parameter int BUS_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        redirect,
    input  logic [15:0] redirect_ptr,
    input  logic [15:0] cs_seg,
    input  logic        pop_ready,
    output logic [2:0]  count,
    output logic        empty,
    output logic        req_valid,
    output int          checks,
    output int          fails
);

    localparam int BB    = BUS_W / 8;
    localparam int DEPTH = 6;

    logic             mem_req_ready;
    logic             mem_req_valid;
    logic [19:0]      mem_req_addr;
    logic             mem_req_word;
    logic             mem_rsp_valid;
    logic [BUS_W-1:0] mem_rsp_data;
    logic             pop_valid;
    logic [7:0]       head_byte;

    prefetch_queue #(.BUS_W(BUS_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_seg       (cs_seg),
        .redirect     (redirect),
        .redirect_ptr (redirect_ptr),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_req_word (mem_req_word),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .pop_valid    (pop_valid),
        .pop_ready    (pop_ready),
        .head_byte    (head_byte),
        .count        (count),
        .empty        (empty)
    );

    assign req_valid = mem_req_valid;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] p);
        return ({4'h0, s} << 4) + {4'h0, p};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s bus%0d %s: actual %0h expected %0h", req, BUS_W, what, act, exp);
        end
    endtask

    int          exp_cnt;
    int          gen;
    int          out_gen;
    int          lat;
    int          push_sz;
    bit          outst;
    bit          out_word;
    bit          rsp_now;
    bit          popn;
    logic [19:0] out_addr;
    logic [15:0] fptr;
    logic [15:0] cptr;
    logic [15:0] wdata;

    initial begin
        checks = 0;
        fails = 0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                exp_cnt = 0; gen = 0; outst = 0; lat = 0;
                fptr = '0; cptr = '0;
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b0;
            end else begin
                chk(int'(count) == exp_cnt, "R8 R11", "count", 32'(count), 32'(exp_cnt));
                chk(pop_valid == (exp_cnt != 0), "R12", "pop_valid", 32'(pop_valid), 32'(exp_cnt != 0));
                chk(empty == (exp_cnt == 0), "R12", "empty", 32'(empty), 32'(exp_cnt == 0));

                // memory response (stale ones, R8, push nothing)
                rsp_now = 0;
                if (outst) begin
                    if (lat > 0) lat--;
                    if (lat == 0) begin rsp_now = 1; outst = 0; end
                end
                if (BB == 2) wdata = {mem_byte({out_addr[19:1], 1'b1}), mem_byte({out_addr[19:1], 1'b0})};
                else         wdata = {8'h00, mem_byte(out_addr)};
                mem_rsp_valid = rsp_now;
                mem_rsp_data  = rsp_now ? wdata[BUS_W-1:0] : '0;
                push_sz = (rsp_now && out_gen == gen && !redirect) ? (out_word ? 2 : 1) : 0;

                // request side
                mem_req_ready = ($urandom % 10) < 7;
                if (mem_req_valid && mem_req_ready) begin
                    chk(mem_req_addr == phys(cs_seg, fptr), "R4 R9", "address",
                        32'(mem_req_addr), 32'(phys(cs_seg, fptr)));
                    chk(int'(count) <= DEPTH - BB, (BB == 2) ? "R2" : "R3", "count at request",
                        32'(count), 32'(DEPTH - BB));
                    chk(mem_req_word == (BB == 2 && !fptr[0]), fptr[0] ? "R7" : "R6", "word flag",
                        32'(mem_req_word), 32'(BB == 2 && !fptr[0]));
                    outst = 1; out_gen = gen; out_word = mem_req_word;
                    out_addr = mem_req_addr; lat = 1 + int'($urandom % 3);
                end

                // consumer side
                popn = pop_valid && pop_ready && !redirect;
                if (popn) begin
                    chk(head_byte == mem_byte(phys(cs_seg, cptr)), "R6 R1", "head_byte",
                        32'(head_byte), 32'(mem_byte(phys(cs_seg, cptr))));
                    cptr = cptr + 16'd1;
                end

                fptr = fptr + 16'(push_sz);
                exp_cnt = redirect ? 0 : exp_cnt + push_sz - int'(popn);
                if (redirect) begin
                    gen++;
                    fptr = redirect_ptr;
                    cptr = redirect_ptr;
                end
            end
        end
    end

endmodule

module prefetch_queue_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect = 1'b0;
    logic [15:0] redirect_ptr = '0;
    logic [15:0] cs_seg = '0;
    logic        pop_ready = 1'b0;

    logic [2:0] cnt16, cnt8;
    logic       emp16, emp8, rq16, rq8;
    int         chk16, chk8, fl16, fl8;
    int         t_checks = 0;
    int         t_fails = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    pfq_lane #(.BUS_W(16)) lane16 (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_ptr(redirect_ptr),
        .cs_seg(cs_seg), .pop_ready(pop_ready), .count(cnt16), .empty(emp16),
        .req_valid(rq16), .checks(chk16), .fails(fl16)
    );

    pfq_lane #(.BUS_W(8)) lane8 (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_ptr(redirect_ptr),
        .cs_seg(cs_seg), .pop_ready(pop_ready), .count(cnt8), .empty(emp8),
        .req_valid(rq8), .checks(chk8), .fails(fl8)
    );

    task automatic tchk(input bit ok, input string req, input string what,
                        input int act, input int exp);
        t_checks++;
        if (!ok) begin
            t_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            redirect = 1'b0;
        end
    endtask

    task automatic jump(input logic [15:0] seg, input logic [15:0] ptr);
        @(posedge clk);
        #1;
        redirect = 1'b1;
        redirect_ptr = ptr;
        cs_seg = seg;
        @(posedge clk);
        #1;
        redirect = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        t_checks = t_checks + chk16 + chk8;
        t_fails  = t_fails + fl16 + fl8;
        $display("  [TB] %0d tests run, %0d failed", t_checks, t_fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        tchk(cnt16 == 3'd0 && emp16, "R13", "bus16 count/empty in reset", int'(cnt16), 0);
        tchk(cnt8 == 3'd0 && emp8, "R13", "bus8 count/empty in reset", int'(cnt8), 0);
        tchk(!rq16 && !rq8, "R13", "request during reset", int'(rq16) + int'(rq8), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1, R3: fill with no consumption
        pop_ready = 1'b0;
        step(90);
        @(negedge clk);
        tchk(cnt16 == 3'd6, "R1", "bus16 full level", int'(cnt16), 6);
        tchk(cnt8 == 3'd6, "R3", "bus8 full level", int'(cnt8), 6);

        // R7: odd start realigns, word bus settles at 5
        jump(16'h1234, 16'h0101);
        @(negedge clk);
        tchk(emp16 && emp8, "R5", "empty after redirect", int'(cnt16) + int'(cnt8), 0);
        step(90);
        @(negedge clk);
        tchk(cnt16 == 3'd5, "R7", "bus16 level after odd start", int'(cnt16), 5);
        tchk(cnt8 == 3'd6, "R3", "bus8 level after odd start", int'(cnt8), 6);

        // R9: pointer wrap near the top of the window, segment 0xFFFF
        jump(16'hFFFF, 16'hFFFB);
        pop_ready = 1'b1;
        step(80);
        pop_ready = 1'b0;
        jump(16'h0F00, 16'hFFFE);
        step(60);
        @(negedge clk);
        tchk(cnt16 == 3'd6, "R9", "bus16 level after wrap fill", int'(cnt16), 6);

        // random mix: pops, stalls, redirects colliding with fetches (R5 R8 R10 R11)
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk);
            #1;
            pop_ready = ($urandom % 10) < 6;
            redirect = ($urandom % 32) == 0;
            if (redirect) begin
                redirect_ptr = 16'($urandom);
                if ($urandom % 2) cs_seg = 16'($urandom);
            end
        end
        @(posedge clk);
        #1;
        redirect = 1'b0;
        step(10);

        tchk(chk16 > 1000 && chk8 > 1000, "R12", "lane check activity", chk16, 1000);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            t_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule